// File: doc/BRIEF.md
# Board Control Register Bank

This block is a small bank of board-level control and status registers on a plain 32-bit bus. The bus has an address, a write strobe, a read strobe, write data and read data. Each strobe is sampled on a rising clock edge. Read data is registered and is valid in the cycle after the read strobe. Only the low 20 address bits take part in decoding.

The bank drives the following outputs:
- an 8-bit LED bar;
- an eight-character text buffer for an external display;
- a general-purpose output byte;
- a one-cycle soft-reset request;
- a bit-banged two-wire serial port, with clock and data drive lines, an output-enable pair and a port select bit.

Software can fill the text buffer in two ways. It can write one 32-bit word, which is shown as eight uppercase hexadecimal digits. It can also write single characters through eight position registers spaced 8 bytes apart. The byte window 0x900 to 0x9FF is left to a separate serial controller, so this block ignores it.

Address map (low 20 bits):
- 0x00108: LED bar
- 0x00200: switch register
- 0x00410: hex word
- 0x00418 + 8*i: character i, for i = 0 to 7
- 0x00500: soft reset
- 0x00A10: general-purpose output
- 0x00B20: serial output enable
- 0x00B28: serial lines
- 0x00B30: serial input
- 0x00B38: serial select

Top module: `board_ctrl_regs`

## Requirements
- R1: Decoding uses only addr[19:0]. Any value in addr[31:20] reaches the same register.
- R2: A write to the LED bar (0x00108) keeps only wdata[7:0]. That byte appears on `led` and reads back with zeros above it.
- R3: A write to the hex word register (0x00410) turns wdata into eight uppercase ASCII hex digits. Digits 0 to 9 become 0x30 to 0x39, and A to F become 0x41 to 0x46. Character 0 takes wdata[31:28] and character 7 takes wdata[3:0]. Character i appears on disp_text[8i+7:8i].
- R4: Character register i sits at 0x00418 + 8*i. A write there stores wdata[7:0] as character i and leaves the other characters unchanged. A read there returns character i.
- R5: The switch register (0x00200) always reads 0.
- R6: The general-purpose output (0x00A10) keeps 8 bits. The serial output enable (0x00B20) keeps 2 bits. The serial select (0x00B38) keeps 1 bit. Each drives its own output port and reads back as stored.
- R7: A write to the serial line register (0x00B28) sets `i2c_scl_o` to wdata[1] and `i2c_sda_o` to wdata[0].
- R8: The serial input register (0x00B30) stores wdata[7:0]. A read returns the stored bits 7:1, with bit 0 replaced by the live `i2c_sda_i` level.
- R9: A write to 0x00500 with wdata[7:0] = 0x42 raises `soft_rst_req` for exactly the one following cycle. Any other data gives no pulse.
- R10: Offsets 0x900 to 0x9FF belong to another block. Reads there return 0 without `bad_access`, and writes there change no register.
- R11: A read from any other undecoded offset returns 0 and raises `bad_access` for one cycle, alongside the read data.
- R12: After reset every character is a space (0x20). The LED, general-purpose and serial registers are all 0, and so are `soft_rst_req` and `bad_access`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 32 | Bus address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| bad_access | output | 1 | One-cycle flag for a read of an undecoded offset |
| led | output | 8 | LED bar |
| disp_text | output | 64 | Display characters; character i in bits 8i+7:8i |
| gpo | output | 8 | General-purpose output byte |
| soft_rst_req | output | 1 | One-cycle soft-reset request |
| i2c_oe | output | 2 | Serial output enables |
| i2c_sel | output | 1 | Serial port select |
| i2c_scl_o | output | 1 | Serial clock drive |
| i2c_sda_o | output | 1 | Serial data drive |
| i2c_sda_i | input | 1 | Serial data level returned by the slave |

## Verification
The hardest behaviour to reach from the ports is the word-to-hex conversion at the digit boundary 9/A and at both ends of the buffer. It only shows up when the right nibble lands in the right position. The stimulus writes the words 0xDEADBEEF and 0x0000009A. It then reads characters 0, 4, 6 and 7 back through their position registers, and separately compares the whole `disp_text` output after writing 0x0123ABCD. A second case that needs care is an address with non-zero upper bits. The stimulus writes the LED bar at 0xABC00108 and reads it back at the plain offset.

// File: rtl/board_ctrl_regs.sv
module board_ctrl_regs #(
  parameter int DEC_W = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] addr,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        bad_access,
  output logic [7:0]  led,
  output logic [63:0] disp_text,
  output logic [7:0]  gpo,
  output logic        soft_rst_req,
  output logic [1:0]  i2c_oe,
  output logic        i2c_sel,
  output logic        i2c_scl_o,
  output logic        i2c_sda_o,
  input  logic        i2c_sda_i
);
  localparam logic [DEC_W-1:0] OFS_LED   = 'h00108;
  localparam logic [DEC_W-1:0] OFS_SW    = 'h00200;
  localparam logic [DEC_W-1:0] OFS_WORD  = 'h00410;
  localparam logic [DEC_W-1:0] OFS_POS   = 'h00418;
  localparam logic [DEC_W-1:0] OFS_SRST  = 'h00500;
  localparam logic [DEC_W-1:0] OFS_GPO   = 'h00A10;
  localparam logic [DEC_W-1:0] OFS_OE    = 'h00B20;
  localparam logic [DEC_W-1:0] OFS_LINES = 'h00B28;
  localparam logic [DEC_W-1:0] OFS_IN    = 'h00B30;
  localparam logic [DEC_W-1:0] OFS_SEL   = 'h00B38;
  localparam int CHARS = 8;

  logic [DEC_W-1:0] a, pos_off;
  logic [7:0] chr [CHARS];
  logic [7:0] in_q;
  logic [1:0] lines_q;
  logic pos_hit, uart_hit, rd_hit;
  logic [31:0] rd_val;
  logic [2:0] idx;
  logic unused_addr_hi;

  assign a = addr[DEC_W-1:0];
  assign unused_addr_hi = ^addr[31:DEC_W];
  assign pos_off = a - OFS_POS;
  assign pos_hit = (pos_off < DEC_W'(8 * CHARS)) && (pos_off[2:0] == 3'd0);
  assign idx = pos_off[5:3];
  assign uart_hit = (a[DEC_W-1:8] == (DEC_W-8)'('h009));
  assign i2c_scl_o = lines_q[1];
  assign i2c_sda_o = lines_q[0];

  function automatic logic [7:0] hex_chr(input logic [3:0] n);
    return (n < 4'd10) ? 8'h30 + 8'(n) : 8'h37 + 8'(n);
  endfunction

  for (genvar g = 0; g < CHARS; g++) begin : g_text
    assign disp_text[8*g +: 8] = chr[g];
  end

  always_comb begin
    rd_hit = 1'b1;
    rd_val = '0;
    if (pos_hit) rd_val = {24'd0, chr[idx]};
    else if (uart_hit) rd_val = '0;
    else begin
      case (a)
        OFS_LED:   rd_val = {24'd0, led};
        OFS_SW, OFS_WORD, OFS_SRST: rd_val = '0;
        OFS_GPO:   rd_val = {24'd0, gpo};
        OFS_OE:    rd_val = {30'd0, i2c_oe};
        OFS_LINES: rd_val = {30'd0, lines_q};
        OFS_IN:    rd_val = {24'd0, in_q[7:1], i2c_sda_i};
        OFS_SEL:   rd_val = {31'd0, i2c_sel};
        default:   rd_hit = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < CHARS; i++) chr[i] <= 8'h20;
      led <= '0; gpo <= '0; i2c_oe <= '0; i2c_sel <= 1'b0;
      lines_q <= '0; in_q <= '0;
      soft_rst_req <= 1'b0; bad_access <= 1'b0; rdata <= '0;
    end else begin
      soft_rst_req <= wr_en && (a == OFS_SRST) && (wdata[7:0] == 8'h42);
      bad_access <= rd_en && !rd_hit;
      if (rd_en) rdata <= rd_hit ? rd_val : '0;
      if (wr_en && !uart_hit) begin
        if (pos_hit) chr[idx] <= wdata[7:0];
        case (a)
          OFS_LED:   led <= wdata[7:0];
          OFS_WORD:  for (int i = 0; i < CHARS; i++) chr[i] <= hex_chr(wdata[31-4*i -: 4]);
          OFS_GPO:   gpo <= wdata[7:0];
          OFS_OE:    i2c_oe <= wdata[1:0];
          OFS_LINES: lines_q <= wdata[1:0];
          OFS_IN:    in_q <= wdata[7:0];
          OFS_SEL:   i2c_sel <= wdata[0];
          default: ;
        endcase
      end
    end
  end
endmodule

module board_ctrl_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [19:0] addr_lo,
  input logic        wr_en,
  input logic        rd_en,
  input logic [31:0] wdata,
  input logic [31:0] rdata,
  input logic        bad_access,
  input logic [7:0]  led,
  input logic        soft_rst_req,
  input logic        i2c_scl_o,
  input logic        i2c_sda_o
);
  a_r2_led_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr_lo == 20'h00108) |=> (led == $past(wdata[7:0])));
  a_r7_i2c_lines: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr_lo == 20'h00B28) |=> ({i2c_scl_o, i2c_sda_o} == $past(wdata[1:0])));
  a_r9_pulse_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(soft_rst_req) |-> $past(wr_en && addr_lo == 20'h00500 && wdata[7:0] == 8'h42));
  a_r10_window_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr_lo[19:8] == 12'h009) |=> $stable(led));
  a_r11_bad_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bad_access |-> (rdata == 32'd0 && $past(rd_en)));
endmodule

bind board_ctrl_regs board_ctrl_regs_chk i_chk (
  .clk(clk), .rst_n(rst_n), .addr_lo(addr[19:0]), .wr_en(wr_en), .rd_en(rd_en),
  .wdata(wdata), .rdata(rdata), .bad_access(bad_access), .led(led),
  .soft_rst_req(soft_rst_req), .i2c_scl_o(i2c_scl_o), .i2c_sda_o(i2c_sda_o)
);

// File: tb/test_board_ctrl_regs.sv
module test_board_ctrl_regs;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0, sda_i = 1'b1;
  logic [31:0] addr = '0, wdata = '0, rdata;
  logic bad_access, soft_rst_req, i2c_sel, i2c_scl_o, i2c_sda_o;
  logic [7:0] led, gpo;
  logic [63:0] disp_text;
  logic [1:0] i2c_oe;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  board_ctrl_regs i_board_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .bad_access(bad_access), .led(led),
    .disp_text(disp_text), .gpo(gpo), .soft_rst_req(soft_rst_req),
    .i2c_oe(i2c_oe), .i2c_sel(i2c_sel), .i2c_scl_o(i2c_scl_o),
    .i2c_sda_o(i2c_sda_o), .i2c_sda_i(sda_i));

  // {req, is_write, addr, data, expected read}
  localparam int NV = 24;
  localparam logic [100:0] VEC [NV] = '{
    {4'd2,  1'b1, 32'h00108, 32'h123456A5, 32'h0},   // R2
    {4'd2,  1'b0, 32'h00108, 32'h0, 32'hA5},
    {4'd3,  1'b1, 32'h00410, 32'hDEADBEEF, 32'h0},   // R3
    {4'd3,  1'b0, 32'h00418, 32'h0, 32'h44},
    {4'd3,  1'b0, 32'h00438, 32'h0, 32'h42},
    {4'd3,  1'b0, 32'h00450, 32'h0, 32'h46},
    {4'd3,  1'b1, 32'h00410, 32'h0000009A, 32'h0},
    {4'd3,  1'b0, 32'h00448, 32'h0, 32'h39},
    {4'd3,  1'b0, 32'h00450, 32'h0, 32'h41},
    {4'd3,  1'b0, 32'h00418, 32'h0, 32'h30},
    {4'd4,  1'b1, 32'h00428, 32'h12345677, 32'h0},   // R4
    {4'd4,  1'b0, 32'h00428, 32'h0, 32'h77},
    {4'd4,  1'b0, 32'h00420, 32'h0, 32'h30},
    {4'd6,  1'b1, 32'h00A10, 32'hFFFFFF3C, 32'h0},   // R6
    {4'd6,  1'b0, 32'h00A10, 32'h0, 32'h3C},
    {4'd6,  1'b1, 32'h00B20, 32'hFF, 32'h0},
    {4'd6,  1'b0, 32'h00B20, 32'h0, 32'h3},
    {4'd6,  1'b1, 32'h00B38, 32'hFF, 32'h0},
    {4'd6,  1'b0, 32'h00B38, 32'h0, 32'h1},
    {4'd5,  1'b0, 32'h00200, 32'h0, 32'h0},          // R5
    {4'd1,  1'b1, 32'hABC00108, 32'h5A, 32'h0},      // R1
    {4'd1,  1'b0, 32'h00108, 32'h0, 32'h5A},
    {4'd8,  1'b1, 32'h00B30, 32'hF0, 32'h0},         // R8
    {4'd8,  1'b0, 32'h00B30, 32'h0, 32'hF1}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] ad, input logic [31:0] d);
    @(negedge clk); addr = ad; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [31:0] ad);
    @(negedge clk); addr = ad; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 text", disp_text, {8{8'h20}});
    chk("R12 regs", {led, gpo, 5'd0, i2c_oe, i2c_sel}, 32'd0);
    chk("R12 pulses", {soft_rst_req, bad_access, i2c_scl_o, i2c_sda_o}, 4'd0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][96]) wr(VEC[i][95:64], VEC[i][63:32]);
      else begin
        rd(VEC[i][95:64]);
        checks++;
        if (rdata !== VEC[i][31:0]) begin
          fails++;
          $display("FAIL R%0d vector %0d: actual %h expected %h", VEC[i][100:97], i, rdata, VEC[i][31:0]);
        end
      end
    end
    // R2 / R6 outputs
    chk("R2 led port", led, 8'h5A);
    chk("R6 ports", {gpo, i2c_oe, i2c_sel}, {8'h3C, 2'b11, 1'b1});
    // R3 full buffer
    wr(32'h00410, 32'h0123ABCD);
    chk("R3 text", disp_text, 64'h4443424133323130);
    // R7 lines
    wr(32'h00B28, 32'h2);
    chk("R7 lines", {i2c_scl_o, i2c_sda_o}, 2'b10);
    wr(32'h00B28, 32'h1);
    chk("R7 lines", {i2c_scl_o, i2c_sda_o}, 2'b01);
    // R8 live sda
    sda_i = 1'b0;
    rd(32'h00B30);
    chk("R8 sda low", rdata, 32'hF0);
    // R9 pulse
    @(negedge clk); addr = 32'h00500; wdata = 32'h42; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    chk("R9 pulse high", soft_rst_req, 1'b1);
    @(negedge clk);
    chk("R9 pulse one cycle", soft_rst_req, 1'b0);
    @(negedge clk); addr = 32'h00500; wdata = 32'h41; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    chk("R9 no pulse", soft_rst_req, 1'b0);
    // R10 uart window
    wr(32'h00908, 32'hFF);
    chk("R10 state", {led, gpo, disp_text}, {8'h5A, 8'h3C, 64'h4443424133323130});
    rd(32'h009F0);
    chk("R10 read", {bad_access, rdata}, 33'd0);
    // R11 bad access
    rd(32'h007FC);
    chk("R11 flag", {bad_access, rdata}, {1'b1, 32'd0});
    @(negedge clk);
    chk("R11 one cycle", bad_access, 1'b0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule